// File: doc/BRIEF.md
# EDO Page-Mode DRAM Pin Model

This block stands in for an asynchronous extended-data-out DRAM on the pins that a memory controller drives. It is built to be synthesized next to the controller and used as its self-checking target. A fast system clock samples the row strobe, the two byte-lane column strobes, write enable, output enable, the multiplexed address and the write data. Commands are decoded only from the order in which the strobes change. The array is kept small: a reduced number of rows and columns held in a register array. It stores 16-bit words written per byte lane.

A row opens when the row strobe falls while both column strobes are high. A column strobe, or output enable, then starts a read or a write. Read data stays on the bus after the column strobe rises and is replaced only on the next column fall. The same decode covers the three refresh flavours: row-strobe-only, column-before-row (row taken from an internal counter), and hidden refresh, where the row strobe toggles under a held read. The block raises a readiness flag once the power-up pause and the wake-up row cycles have been seen. Each row carries an age counter, and the block flags any row left unrefreshed too long.

A pin change first seen at one rising clock edge reaches the registered outputs after the next rising edge.

Top module: `edo_dram_model`

## Requirements
- R1: When the row strobe falls while at least one column strobe is already low, the block performs a counter refresh. `ref_stb` pulses with `ref_row` equal to the low ROW_W bits of an internal counter, which is 0 after reset and steps by one per counter refresh. The address pins and write data are ignored, no word is stored and `dq_oe` stays 2'b00.
- R2: A row strobe fall with both column strobes high latches the row from the address. When the row strobe rises, `ref_stb` pulses with that row. If no column strobe fell in that cycle, the bus is never driven.
- R3: The internal column function starts on the first of the two column strobes to fall, and the column address is latched there. It ends only when the last of them rises, so a lane strobe that rises and falls again while the other stays low latches no new column.
- R4: A read starts on the later of the column fall and the output-enable fall, with write enable high. It drives `dq_out` with the stored word. `dq_oe[0]` covers bits 7:0 and follows the lower-lane strobe; `dq_oe[1]` covers bits 15:8 and follows the upper-lane strobe. A lane starts to drive only once its own strobe has fallen in the current row cycle.
- R5: A write starts on the later of the column fall and the write-enable fall. Only lanes whose column strobe is low are stored, and the bus is released during the write.
- R6: Within an open row, read data stays driven after the column strobes rise and changes only at the next column fall. Outputs turn off when the row strobe and both column strobes are high, on a rise of output enable, or on a fall of write enable.
- R7: When the row strobe rises and falls again while a column strobe stays low during a read, the driven data and lanes are kept unchanged and a counter refresh as in R1 takes place.
- R8: `ready` is 0 from reset and becomes 1, then stays 1, once INIT_PAUSE clocks have passed and INIT_RAS row-strobe rises have been seen after that pause.
- R9: Every row has an age counter that is cleared by any refresh of that row (R1, R2) and counts clocks otherwise. `stale` is 1 while any row's age has reached REF_LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DATA_W | Write data from the controller |
| dq_out | output | DATA_W | Read data; zero in lanes not driven |
| dq_oe | output | 2 | Per-lane drive enable |
| ready | output | 1 | Power-up sequence complete |
| ref_stb | output | 1 | One-cycle pulse per row refresh |
| ref_row | output | ROW_W | Row refreshed by the current pulse |
| stale | output | 1 | Some row exceeded the refresh age limit |

## Verification
Two functions can fall in the same cycle: a held read on the bus, and a counter refresh started under it. The bench provokes this with a hidden refresh. It opens a read, raises the row strobe and lowers it again while a column strobe stays low. It then judges that the lanes and data seen before the toggle are still on the bus, and that the refresh pulse carried the counter row and not the accessed one. A second overlap is a fall of write enable during a held page read. The bench checks that this releases the bus and does not store anything.

// File: rtl/edo_pkg.sv
package edo_pkg;

  localparam int LANES = 2;

  typedef struct packed {
    logic ras_n;
    logic lcas_n;
    logic ucas_n;
    logic we_n;
    logic oe_n;
  } strobes_t;

  localparam strobes_t STROBES_IDLE = '{ras_n: 1'b1, lcas_n: 1'b1, ucas_n: 1'b1,
                                        we_n: 1'b1, oe_n: 1'b1};

  // internal column function: active while either lane strobe is low
  function automatic logic cas_active(input strobes_t s);
    return ~s.lcas_n | ~s.ucas_n;
  endfunction

  // per-lane asserted strobes, bit 0 lower lane, bit 1 upper lane
  function automatic logic [LANES-1:0] lanes_low(input strobes_t s);
    return {~s.ucas_n, ~s.lcas_n};
  endfunction

  // lanes whose strobe went from high to low between two samples
  function automatic logic [LANES-1:0] lanes_fell(input strobes_t prv, input strobes_t cur);
    return lanes_low(cur) & ~lanes_low(prv);
  endfunction

endpackage

// File: rtl/edo_pin_sampler.sv
module edo_pin_sampler
  import edo_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          pins,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output strobes_t          cur,
  output strobes_t          prv,
  output logic [ADDR_W-1:0] addr_s,
  output logic [DATA_W-1:0] din_s
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= STROBES_IDLE;
      prv    <= STROBES_IDLE;
      addr_s <= '0;
      din_s  <= '0;
    end else begin
      cur    <= pins;
      prv    <= cur;
      addr_s <= addr;
      din_s  <= din;
    end
  end

endmodule

// File: rtl/edo_init_tracker.sv
module edo_init_tracker #(
  parameter int INIT_PAUSE = 16,
  parameter int INIT_RAS   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_rise,
  output logic ready
);

  localparam int PW = $clog2(INIT_PAUSE + 1);
  localparam int RW = $clog2(INIT_RAS + 1);

  logic [PW-1:0] pause_q;
  logic [RW-1:0] wake_q;
  logic          pause_done;

  assign pause_done = (pause_q == PW'(INIT_PAUSE));
  assign ready      = (wake_q == RW'(INIT_RAS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_q <= '0;
      wake_q  <= '0;
    end else begin
      if (!pause_done) pause_q <= pause_q + PW'(1);
      if (pause_done && ras_rise && !ready) wake_q <= wake_q + RW'(1);
    end
  end

endmodule

// File: rtl/edo_refresh_monitor.sv
module edo_refresh_monitor #(
  parameter int ROW_W     = 3,
  parameter int REF_LIMIT = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_stb,
  input  logic [ROW_W-1:0] ref_row,
  output logic             stale
);

  localparam int ROWS  = 1 << ROW_W;
  localparam int AGE_W = $clog2(REF_LIMIT + 1);

  logic [ROWS-1:0] over;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   age_q <= '0;
      else if (ref_stb && ref_row == ROW_W'(r))     age_q <= '0;
      else if (age_q != AGE_W'(REF_LIMIT))          age_q <= age_q + AGE_W'(1);
    end
    assign over[r] = (age_q == AGE_W'(REF_LIMIT));
  end

  assign stale = |over;

endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model
  import edo_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 16,
  parameter int ROW_W      = 3,
  parameter int COL_W      = 3,
  parameter int REF_CNT_W  = 9,
  parameter int INIT_PAUSE = 16,
  parameter int INIT_RAS   = 8,
  parameter int REF_LIMIT  = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [1:0]        dq_oe,
  output logic              ready,
  output logic              ref_stb,
  output logic [ROW_W-1:0]  ref_row,
  output logic              stale
);

  localparam int LANE_W  = DATA_W / LANES;
  localparam int WORDS   = 1 << (ROW_W + COL_W);
  localparam int IDX_W   = ROW_W + COL_W;
  localparam int USED_AW = (ROW_W > COL_W) ? ROW_W : COL_W;

  // sampled pins
  strobes_t          pins, s_cur, s_prv;
  logic [ADDR_W-1:0] a_s;
  logic [DATA_W-1:0] d_s;

  assign pins = '{ras_n: ras_n, lcas_n: lcas_n, ucas_n: ucas_n, we_n: we_n, oe_n: oe_n};

  edo_pin_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins   (pins),
    .addr   (addr),
    .din    (dq_in),
    .cur    (s_cur),
    .prv    (s_prv),
    .addr_s (a_s),
    .din_s  (d_s)
  );

  logic unused_addr_hi;
  assign unused_addr_hi = ^a_s[ADDR_W-1:USED_AW];

  // state
  logic                 ras_act_q, cbr_q, cas_seen_q;
  logic [ROW_W-1:0]     row_q;
  logic [COL_W-1:0]     col_q;
  logic [DATA_W-1:0]    rd_q;
  logic [LANES-1:0]     drv_q;
  logic [REF_CNT_W-1:0] ref_cnt_q;
  logic                 ref_stb_q;
  logic [ROW_W-1:0]     ref_row_q;
  logic [DATA_W-1:0]    mem [WORDS];

  // named events
  logic             cas_now, cas_was, ras_high;
  logic             ras_fall, ras_rise, cas_fall, cas_rise;
  logic             we_fall, oe_fall, oe_rise;
  logic [LANES-1:0] lane_now, lane_fall;
  logic             cbr_evt, row_open_evt, in_access, rasonly_evt;
  logic             rd_start, rd_lane_add, wr_evt, bus_idle, ref_evt;
  logic [LANES-1:0] wr_mask;
  logic [COL_W-1:0] col_now;
  logic [IDX_W-1:0] word_idx;

  assign cas_now   = cas_active(s_cur);
  assign cas_was   = cas_active(s_prv);
  assign ras_high  = s_cur.ras_n;
  assign ras_fall  = s_prv.ras_n & ~s_cur.ras_n;
  assign ras_rise  = ~s_prv.ras_n & s_cur.ras_n;
  assign cas_fall  = cas_now & ~cas_was;
  assign cas_rise  = ~cas_now & cas_was;
  assign we_fall   = s_prv.we_n & ~s_cur.we_n;
  assign oe_fall   = s_prv.oe_n & ~s_cur.oe_n;
  assign oe_rise   = ~s_prv.oe_n & s_cur.oe_n;
  assign lane_now  = lanes_low(s_cur);
  assign lane_fall = lanes_fell(s_prv, s_cur);

  assign cbr_evt      = ras_fall & cas_was;
  assign row_open_evt = ras_fall & ~cas_was;
  assign in_access    = ras_act_q & ~cbr_q;
  assign rasonly_evt  = ras_rise & in_access & ~cas_seen_q;
  assign ref_evt      = cbr_evt | (ras_rise & in_access);

  assign col_now  = cas_fall ? a_s[COL_W-1:0] : col_q;
  assign word_idx = {row_q, col_now};

  assign rd_start    = in_access & cas_now & s_cur.we_n & ~s_cur.oe_n & (cas_fall | oe_fall);
  assign rd_lane_add = in_access & s_cur.we_n & ~s_cur.oe_n & (|lane_fall) & ~cas_fall;
  assign wr_evt      = in_access & cas_now & ~s_cur.we_n & (cas_fall | we_fall | (|lane_fall));
  assign wr_mask     = (cas_fall | we_fall) ? lane_now : lane_fall;
  assign bus_idle    = s_cur.ras_n & ~cas_now;

  // control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_act_q  <= 1'b0;
      cbr_q      <= 1'b0;
      cas_seen_q <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      ref_cnt_q  <= '0;
      ref_stb_q  <= 1'b0;
      ref_row_q  <= '0;
    end else begin
      ref_stb_q <= ref_evt;
      if (ref_evt) ref_row_q <= cbr_evt ? ref_cnt_q[ROW_W-1:0] : row_q;
      if (cbr_evt) begin
        ras_act_q <= 1'b1;
        cbr_q     <= 1'b1;
        ref_cnt_q <= ref_cnt_q + REF_CNT_W'(1);
      end else if (row_open_evt) begin
        ras_act_q  <= 1'b1;
        cbr_q      <= 1'b0;
        cas_seen_q <= 1'b0;
        row_q      <= a_s[ROW_W-1:0];
      end else if (ras_rise) begin
        ras_act_q <= 1'b0;
        cbr_q     <= 1'b0;
      end
      if (in_access && cas_fall) begin
        col_q      <= a_s[COL_W-1:0];
        cas_seen_q <= 1'b1;
      end
    end
  end

  // bus drive and read data
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_q <= '0;
      rd_q  <= '0;
    end else begin
      if (rd_start) begin
        drv_q <= lane_now;
        rd_q  <= mem[word_idx];
      end else if (rd_lane_add) begin
        drv_q <= drv_q | (lane_fall & lane_now);
      end
      if (wr_evt || we_fall || oe_rise || bus_idle) drv_q <= '0;
    end
  end

  // array
  always_ff @(posedge clk) begin
    if (wr_evt) begin
      for (int g = 0; g < LANES; g++) begin
        if (wr_mask[g]) mem[word_idx][g*LANE_W +: LANE_W] <= d_s[g*LANE_W +: LANE_W];
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dq_out[g*LANE_W +: LANE_W] = drv_q[g] ? rd_q[g*LANE_W +: LANE_W] : '0;
  end

  assign dq_oe   = drv_q;
  assign ref_stb = ref_stb_q;
  assign ref_row = ref_row_q;

  edo_init_tracker #(.INIT_PAUSE(INIT_PAUSE), .INIT_RAS(INIT_RAS)) u_init (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_rise (ras_rise),
    .ready    (ready)
  );

  edo_refresh_monitor #(.ROW_W(ROW_W), .REF_LIMIT(REF_LIMIT)) u_age (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_stb (ref_stb_q),
    .ref_row (ref_row_q),
    .stale   (stale)
  );

endmodule

// File: rtl/edo_dram_checker.sv
module edo_dram_checker #(
  parameter int ROW_W     = 3,
  parameter int REF_CNT_W = 9,
  parameter int DATA_W    = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cbr_evt,
  input logic                 rasonly_evt,
  input logic                 wr_evt,
  input logic                 oe_rise,
  input logic                 we_fall,
  input logic                 cas_rise,
  input logic                 bus_idle,
  input logic                 ras_high,
  input logic [REF_CNT_W-1:0] ref_cnt,
  input logic                 ref_stb,
  input logic [ROW_W-1:0]     ref_row,
  input logic [1:0]           dq_oe,
  input logic [DATA_W-1:0]    dq_out,
  input logic                 ready
);

  AST_CBR_ROW_FROM_COUNTER: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_evt |=> (ref_stb && ref_row == $past(ref_cnt[ROW_W-1:0]))); // R1

  AST_CBR_COUNTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_evt |=> (ref_cnt == $past(ref_cnt) + REF_CNT_W'(1))); // R1

  AST_RASONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rasonly_evt |=> (dq_oe == 2'b00 && ref_stb)); // R2

  AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (dq_oe == 2'b00)); // R5

  AST_OE_RISE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_rise |=> (dq_oe == 2'b00)); // R6

  AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |=> (dq_oe == 2'b00)); // R6

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_rise && !ras_high && !oe_rise && !we_fall) |=> ($stable(dq_out) && $stable(dq_oe))); // R6

  AST_HIDDEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cbr_evt && dq_oe != 2'b00 && !oe_rise && !we_fall) |=> $stable(dq_oe)); // R7

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R8

endmodule

bind edo_dram_model edo_dram_checker #(
  .ROW_W(ROW_W), .REF_CNT_W(REF_CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cbr_evt     (cbr_evt),
  .rasonly_evt (rasonly_evt),
  .wr_evt      (wr_evt),
  .oe_rise     (oe_rise),
  .we_fall     (we_fall),
  .cas_rise    (cas_rise),
  .bus_idle    (bus_idle),
  .ras_high    (ras_high),
  .ref_cnt     (ref_cnt_q),
  .ref_stb     (ref_stb),
  .ref_row     (ref_row),
  .dq_oe       (dq_oe),
  .dq_out      (dq_out),
  .ready       (ready)
);

// File: tb/tb_edo_dram_model.sv
module tb_edo_dram_model;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic        ready, ref_stb, stale;
  logic [2:0]  ref_row;

  int vectors = 0;
  int fails   = 0;
  int ref_seen = 0;
  logic [2:0] ref_last = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  edo_dram_model dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .ready(ready), .ref_stb(ref_stb), .ref_row(ref_row), .stale(stale)
  );

  // scoreboard of expected bus states
  typedef struct {
    logic [1:0]  oe;
    logic [15:0] data;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      logic [15:0] m;
      e = sb_q.pop_front();
      m = {{8{e.oe[1]}}, {8{e.oe[0]}}};
      vectors++;
      if (dq_oe !== e.oe || dq_out !== (e.data & m)) begin
        fails++;
        $display("FAIL %s bus: oe=%b data=%h expected oe=%b data=%h",
                 e.tag, dq_oe, dq_out, e.oe, e.data & m);
      end
    end
  end

  // refresh pulse observer
  always @(negedge clk) begin
    if (rst_n && ref_stb) begin
      ref_seen++;
      ref_last = ref_row;
    end
  end

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_bus(input logic [1:0] oe, input logic [15:0] data, input string tag);
    exp_t e;
    e.oe = oe; e.data = data; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic check_val(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cbr_cycle();
    lcas_n = 1'b0; ucas_n = 1'b0; settle();
    ras_n = 1'b0; settle();
    ras_n = 1'b1; settle();
    lcas_n = 1'b1; ucas_n = 1'b1; settle();
  endtask

  task automatic write_word(input logic [2:0] row, input logic [2:0] col, input logic [15:0] d);
    addr = {6'd0, row}; ras_n = 1'b0; settle();
    we_n = 1'b0; dq_in = d; addr = {6'd0, col};
    lcas_n = 1'b0; ucas_n = 1'b0; settle();
    lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; settle();
    ras_n = 1'b1; settle();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int cnt0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_bus(2'b00, 16'h0000, "R6 reset");
    check_val("R8", "ready after reset", int'(ready), 0);
    check_val("R9", "stale after reset", int'(stale), 0);

    // wake-up RAS-only cycles after the pause (R8, R2)
    repeat (20) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      addr = 9'(i); ras_n = 1'b0; settle();
      ras_n = 1'b1; settle();
      if (i == 6) check_val("R8", "ready after 7 cycles", int'(ready), 0);
    end
    check_val("R8", "ready after 8 cycles", int'(ready), 1);
    check_val("R2", "refresh pulses", ref_seen, 8);
    check_val("R2", "last refreshed row", int'(ref_last), 7);

    // page-mode early write of two words in row 2 (R5)
    addr = 9'd2; ras_n = 1'b0; settle();
    we_n = 1'b0; dq_in = 16'hA5C3; addr = 9'd5; lcas_n = 1'b0; ucas_n = 1'b0; settle();
    expect_bus(2'b00, 16'h0000, "R5 write no drive");
    lcas_n = 1'b1; ucas_n = 1'b1; settle();
    dq_in = 16'h1234; addr = 9'd6; lcas_n = 1'b0; ucas_n = 1'b0; settle();
    lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; settle();
    ras_n = 1'b1; settle();

    // page-mode read (R4, R6)
    addr = 9'd2; ras_n = 1'b0; settle();
    oe_n = 1'b0; addr = 9'd5; lcas_n = 1'b0; ucas_n = 1'b0; settle();
    expect_bus(2'b11, 16'hA5C3, "R4 word read");
    lcas_n = 1'b1; ucas_n = 1'b1; settle();
    expect_bus(2'b11, 16'hA5C3, "R6 hold after CAS rise");
    addr = 9'd6; lcas_n = 1'b0; ucas_n = 1'b0; settle();
    expect_bus(2'b11, 16'h1234, "R6 new data at next CAS fall");
    oe_n = 1'b1; settle();
    expect_bus(2'b00, 16'h0000, "R6 OE rise releases");
    oe_n = 1'b0; settle();
    expect_bus(2'b11, 16'h1234, "R4 read started by OE fall");
    lcas_n = 1'b1; ucas_n = 1'b1; settle();
    we_n = 1'b0; settle();
    expect_bus(2'b00, 16'h0000, "R6 WE pulse releases");
    we_n = 1'b1; settle();
    ras_n = 1'b1; oe_n = 1'b1; settle();

    // upper-lane write then split-lane read (R5, R4, R3)
    addr = 9'd2; ras_n = 1'b0; settle();
    we_n = 1'b0; dq_in = 16'hFFFF; addr = 9'd5; ucas_n = 1'b0; settle();
    ucas_n = 1'b1; we_n = 1'b1; settle();
    ras_n = 1'b1; settle();
    addr = 9'd2; ras_n = 1'b0; settle();
    oe_n = 1'b0; addr = 9'd5; lcas_n = 1'b0; settle();
    expect_bus(2'b01, 16'h00C3, "R4 lower lane only");
    ucas_n = 1'b0; settle();
    expect_bus(2'b11, 16'hFFC3, "R5 upper lane stored, lower kept");
    lcas_n = 1'b1; settle();
    addr = 9'd6; lcas_n = 1'b0; settle();
    expect_bus(2'b11, 16'hFFC3, "R3 lane re-fall latches no column");
    lcas_n = 1'b1; ucas_n = 1'b1; settle();
    ras_n = 1'b1; settle();
    expect_bus(2'b00, 16'h0000, "R6 all strobes high releases");

    // first CAS fall latches column, then hidden refresh (R3, R7)
    addr = 9'd2; ras_n = 1'b0; settle();
    addr = 9'd6; lcas_n = 1'b0; settle();
    addr = 9'd5; ucas_n = 1'b0; settle();
    expect_bus(2'b11, 16'h1234, "R3 column from first CAS fall");
    ras_n = 1'b1; settle();
    cnt0 = ref_seen;
    ras_n = 1'b0; settle();
    expect_bus(2'b11, 16'h1234, "R7 data kept through hidden refresh");
    check_val("R7", "hidden refresh pulse", ref_seen - cnt0, 1);
    check_val("R7", "hidden refresh row from counter", int'(ref_last), 0);
    lcas_n = 1'b1; ucas_n = 1'b1; settle();
    ras_n = 1'b1; oe_n = 1'b1; settle();

    // CBR with address and write data presented (R1)
    write_word(3'd7, 3'd7, 16'h0F0F);
    lcas_n = 1'b0; settle();
    addr = 9'd7; we_n = 1'b0; dq_in = 16'hDEAD; ras_n = 1'b0; settle();
    expect_bus(2'b00, 16'h0000, "R1 bus quiet in CBR");
    check_val("R1", "CBR row from counter", int'(ref_last), 1);
    ras_n = 1'b1; settle();
    lcas_n = 1'b1; we_n = 1'b1; settle();
    ucas_n = 1'b0; settle();
    ras_n = 1'b0; settle();
    check_val("R1", "CBR counter step", int'(ref_last), 2);
    ras_n = 1'b1; settle();
    ucas_n = 1'b1; settle();
    addr = 9'd7; ras_n = 1'b0; settle();
    oe_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; settle();
    expect_bus(2'b11, 16'h0F0F, "R1 CBR stored nothing");
    lcas_n = 1'b1; ucas_n = 1'b1; oe_n = 1'b1; settle();
    ras_n = 1'b1; settle();

    // RAS-only refresh of row 4 (R2)
    cnt0 = ref_seen;
    addr = 9'd4; ras_n = 1'b0; settle();
    expect_bus(2'b00, 16'h0000, "R2 RAS-only bus quiet");
    ras_n = 1'b1; settle();
    check_val("R2", "RAS-only pulse", ref_seen - cnt0, 1);
    check_val("R2", "RAS-only row", int'(ref_last), 4);

    // refresh age flag (R9)
    for (int i = 0; i < 8; i++) cbr_cycle();
    check_val("R9", "stale after full refresh", int'(stale), 0);
    repeat (3100) @(negedge clk);
    check_val("R9", "stale after idle", int'(stale), 1);
    for (int i = 0; i < 8; i++) cbr_cycle();
    check_val("R9", "stale cleared", int'(stale), 0);

    settle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule